// File: doc/BRIEF.md
# Clock Frequency Ratio Monitor

This block measures how fast one of several candidate clocks runs compared with a fixed reference clock. Software chooses a candidate with a select field and sets a window length in reference cycles. It then writes the start bit. The block counts edges of the chosen clock for the length of the window. It reports the edge count, and the number of window cycles left unused, through plain register-style signals.

A loadable down-counter in the reference domain sets the window. A saturating up-counter in the selected clock's domain does the counting. Start and stop requests cross between the two domains as toggles through two-flop synchronizers. The measured side returns a toggle acknowledge, so the reference side always waits until counting has frozen before it copies the result. If the up-counter fills before the window closes, the measurement ends early. The unused window cycles then stay visible, so software can still form the ratio.

The start bit reads back as `busy` and clears itself in hardware when the measurement finishes.

Top module: `clk_ratio_mon`

## Requirements
- R1: After reset, `busy` and `done` are low, and `meas_count` and `ref_remain` are zero.
- R2: A write (`cfg_we`=1) with `cfg_start`=1 while `busy` is low latches `cfg_sel` and `cfg_window`. `busy` is high and `done` is low after the next `ref_clk` edge.
- R3: The window lasts `cfg_window` reference cycles, and a value of 0 counts as 1. At a normal finish, `meas_count` equals the number of selected-clock edges in the window within plus or minus two.
- R4: `cfg_sel` = i picks input `meas_clks[i]` as the clock being counted.
- R5: On completion, `busy` falls and `done` rises in the same cycle. After a normal (unsaturated) finish, `ref_remain` is zero.
- R6: The measured counter stops at its all-ones value. The measurement then ends before the window is used up: `meas_count` is all-ones, and `ref_remain` holds the unused window cycles within plus or minus five.
- R7: While `busy` is low, `meas_count`, `ref_remain` and `done` keep their values until the next accepted start.
- R8: A write while `busy` is high is ignored. The running measurement keeps its clock and window, and `ref_remain` never rises during a measurement.
- R9: A write with `cfg_start`=0 starts nothing and leaves the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fixed reference clock; all register signals are in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| meas_clks | input | NUM_CLK | Candidate clocks to be measured |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_start | input | 1 | Start bit written with `cfg_we` |
| cfg_sel | input | SEL_W | Index of the clock to measure |
| cfg_window | input | REF_W | Window length in reference cycles |
| busy | output | 1 | Start bit readback; high while a measurement runs |
| done | output | 1 | High once a measurement has completed |
| meas_count | output | MEAS_W | Measured-clock edges counted in the last measurement |
| ref_remain | output | REF_W | Reference down-counter value; unused window after completion |

## Verification
`busy` is due one reference edge after the accepted write, so the bench samples it at the next falling edge. The completion time depends on synchronizer latency in both clock domains and is not fixed. A monitor therefore waits for the rising edge of `done`, samples at falling edges of `ref_clk`, and pops the expected item from a queue. Counts are compared with a tolerance of two edges, or five window cycles after saturation, because the request crossings add a variable delay. Hold checks then look at the outputs many cycles later to confirm that nothing moved.

// File: rtl/crm_pkg.sv
package crm_pkg;
    typedef enum logic [1:0] {
        CRM_IDLE  = 2'd0,
        CRM_RUN   = 2'd1,
        CRM_DRAIN = 2'd2
    } crm_state_e;
endpackage

// File: rtl/crm_sync.sv
// Plain flop chain carrying a slow-changing level into the clk domain.
module crm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d    = sr_q << 1;
        sr_d[0] = d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q = sr_q[STAGES-1];
endmodule

// File: rtl/crm_clk_sel.sv
// Selects one candidate clock; switching happens only while nothing counts.
module crm_clk_sel #(
    parameter int NUM_CLK = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_CLK-1:0] clk_in,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_out
);
    always_comb begin
        clk_out = 1'b0;
        for (int i = 0; i < NUM_CLK; i++) begin
            if (sel == SEL_W'(i)) clk_out = clk_in[i];
        end
    end
endmodule

// File: rtl/crm_meas_cnt.sv
// Measured-clock domain: saturating edge counter driven by toggle requests.
module crm_meas_cnt #(
    parameter int MEAS_W      = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              mclk,
    input  logic              rst_n,
    input  logic              start_tgl,
    input  logic              stop_tgl,
    output logic [MEAS_W-1:0] count,
    output logic              ack_tgl,
    output logic              sat_tgl
);
    localparam logic [MEAS_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [MEAS_W-1:0] cnt;
        logic              running;
        logic              start_seen;
        logic              stop_seen;
        logic              ack;
        logic              sat;
    } mstate_t;

    mstate_t st_d, st_q;
    logic start_s, stop_s;

    crm_sync #(.STAGES(SYNC_STAGES)) u_start_sync (
        .clk(mclk), .rst_n(rst_n), .d(start_tgl), .q(start_s));
    crm_sync #(.STAGES(SYNC_STAGES)) u_stop_sync (
        .clk(mclk), .rst_n(rst_n), .d(stop_tgl), .q(stop_s));

    always_comb begin
        st_d            = st_q;
        st_d.start_seen = start_s;
        st_d.stop_seen  = stop_s;
        // count while running; freeze and report once the top value is hit
        if (st_q.running) begin
            st_d.cnt = st_q.cnt + MEAS_W'(1);
            if (st_d.cnt == CNT_MAX) begin
                st_d.running = 1'b0;
                st_d.sat     = ~st_q.sat;
            end
        end
        // new start request: clear and arm
        if (start_s != st_q.start_seen) begin
            st_d.cnt     = '0;
            st_d.running = 1'b1;
        end
        // stop request: freeze and acknowledge (after start if both arrive)
        if (stop_s != st_q.stop_seen) begin
            st_d.running = 1'b0;
            st_d.ack     = ~st_q.ack;
        end
    end

    always_ff @(posedge mclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign ack_tgl = st_q.ack;
    assign sat_tgl = st_q.sat;
endmodule

// File: rtl/crm_ref_ctrl.sv
// Reference domain: start bit, window down-counter and result capture.
module crm_ref_ctrl
    import crm_pkg::*;
#(
    parameter int MEAS_W      = 14,
    parameter int REF_W       = 9,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_start,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REF_W-1:0]  cfg_window,
    input  logic              ack_tgl,
    input  logic              sat_tgl,
    input  logic [MEAS_W-1:0] meas_count,
    output logic              start_tgl,
    output logic              stop_tgl,
    output logic [SEL_W-1:0]  sel,
    output logic              busy,
    output logic              done,
    output logic [MEAS_W-1:0] result,
    output logic [REF_W-1:0]  remain
);
    typedef struct packed {
        crm_state_e        st;
        logic [REF_W-1:0]  cnt;
        logic [SEL_W-1:0]  sel;
        logic              start_t;
        logic              stop_t;
        logic              ack_seen;
        logic              sat_seen;
        logic              done;
        logic [MEAS_W-1:0] result;
    } rstate_t;

    rstate_t st_d, st_q;
    logic ack_s, sat_s, ack_ev, sat_ev;

    crm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk(clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));
    crm_sync #(.STAGES(SYNC_STAGES)) u_sat_sync (
        .clk(clk), .rst_n(rst_n), .d(sat_tgl), .q(sat_s));

    assign ack_ev = ack_s ^ st_q.ack_seen;
    assign sat_ev = sat_s ^ st_q.sat_seen;

    always_comb begin
        st_d          = st_q;
        st_d.ack_seen = ack_s;
        st_d.sat_seen = sat_s;
        unique case (st_q.st)
            CRM_IDLE: begin
                if (cfg_we && cfg_start) begin
                    st_d.st      = CRM_RUN;
                    st_d.sel     = cfg_sel;
                    st_d.cnt     = (cfg_window == '0) ? REF_W'(1) : cfg_window;
                    st_d.start_t = ~st_q.start_t;
                    st_d.done    = 1'b0;
                end
            end
            CRM_RUN: begin
                if (sat_ev) begin
                    st_d.stop_t = ~st_q.stop_t;
                    st_d.st     = CRM_DRAIN;
                end else if (st_q.cnt == REF_W'(1)) begin
                    st_d.cnt    = '0;
                    st_d.stop_t = ~st_q.stop_t;
                    st_d.st     = CRM_DRAIN;
                end else begin
                    st_d.cnt = st_q.cnt - REF_W'(1);
                end
            end
            CRM_DRAIN: begin
                // counter is frozen once the acknowledge toggles
                if (ack_ev) begin
                    st_d.result = meas_count;
                    st_d.done   = 1'b1;
                    st_d.st     = CRM_IDLE;
                end
            end
            default: st_d.st = CRM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_tgl = st_q.start_t;
    assign stop_tgl  = st_q.stop_t;
    assign sel       = st_q.sel;
    assign busy      = (st_q.st != CRM_IDLE);
    assign done      = st_q.done;
    assign result    = st_q.result;
    assign remain    = st_q.cnt;
endmodule

// File: rtl/clk_ratio_mon.sv
module clk_ratio_mon #(
    parameter int NUM_CLK     = 4,
    parameter int MEAS_W      = 14,
    parameter int REF_W       = 9,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic [NUM_CLK-1:0] meas_clks,
    input  logic               cfg_we,
    input  logic               cfg_start,
    input  logic [SEL_W-1:0]   cfg_sel,
    input  logic [REF_W-1:0]   cfg_window,
    output logic               busy,
    output logic               done,
    output logic [MEAS_W-1:0]  meas_count,
    output logic [REF_W-1:0]   ref_remain
);
    logic              mclk;
    logic [SEL_W-1:0]  sel_q;
    logic              start_tgl, stop_tgl, ack_tgl, sat_tgl;
    logic [MEAS_W-1:0] live_count;

    crm_clk_sel #(.NUM_CLK(NUM_CLK), .SEL_W(SEL_W)) u_sel (
        .clk_in(meas_clks), .sel(sel_q), .clk_out(mclk));

    crm_meas_cnt #(.MEAS_W(MEAS_W), .SYNC_STAGES(SYNC_STAGES)) u_meas (
        .mclk(mclk), .rst_n(rst_n), .start_tgl(start_tgl), .stop_tgl(stop_tgl),
        .count(live_count), .ack_tgl(ack_tgl), .sat_tgl(sat_tgl));

    crm_ref_ctrl #(.MEAS_W(MEAS_W), .REF_W(REF_W), .SEL_W(SEL_W),
                   .SYNC_STAGES(SYNC_STAGES)) u_ref (
        .clk(ref_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
        .cfg_sel(cfg_sel), .cfg_window(cfg_window), .ack_tgl(ack_tgl),
        .sat_tgl(sat_tgl), .meas_count(live_count), .start_tgl(start_tgl),
        .stop_tgl(stop_tgl), .sel(sel_q), .busy(busy), .done(done),
        .result(meas_count), .remain(ref_remain));
endmodule

// File: rtl/crm_checker.sv
module crm_checker #(
    parameter int MEAS_W = 14,
    parameter int REF_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_start,
    input logic              busy,
    input logic              done,
    input logic [MEAS_W-1:0] meas_count,
    input logic [REF_W-1:0]  ref_remain
);
    localparam logic [MEAS_W-1:0] FULL = '1;

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && cfg_start) |=> (busy && !done));

    a_r5_done_with_busy_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));

    a_r5_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r5_window_used_up: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && meas_count != FULL) |-> (ref_remain == '0));

    a_r6_early_end_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && ref_remain != '0) |-> (meas_count == FULL));

    a_r7_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(meas_count) && $stable(ref_remain)));

    a_r8_window_never_reloaded: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (ref_remain <= $past(ref_remain)));

    a_r9_no_start_no_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && !cfg_start) |=> !busy);
endmodule

bind clk_ratio_mon crm_checker #(.MEAS_W(MEAS_W), .REF_W(REF_W)) u_chk (
    .clk(ref_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_start(cfg_start),
    .busy(busy), .done(done), .meas_count(meas_count), .ref_remain(ref_remain));

// File: tb/sim_clk_ratio_mon.sv
`timescale 1ns/1ps
module sim_clk_ratio_mon;
    localparam int  MW      = 10;
    localparam int  RW      = 9;
    localparam real REF_PER = 5.0;
    localparam int  FULLV   = (1 << MW) - 1;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic mc0 = 1'b0, mc1 = 1'b0, mc2 = 1'b0, mc3 = 1'b0;
    logic [3:0]    meas_clks;
    logic          cfg_we = 1'b0, cfg_start = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [RW-1:0] cfg_window = '0;
    logic          busy, done;
    logic [MW-1:0] meas_count;
    logic [RW-1:0] ref_remain;

    always #2.5  ref_clk = ~ref_clk;
    always #3.85 mc0 = ~mc0;
    always #1.55 mc1 = ~mc1;
    always #5.65 mc2 = ~mc2;
    always #0.85 mc3 = ~mc3;
    assign meas_clks = {mc3, mc2, mc1, mc0};

    real per [4] = '{7.7, 3.1, 11.3, 1.7};

    clk_ratio_mon #(.NUM_CLK(4), .MEAS_W(MW), .REF_W(RW)) u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .meas_clks(meas_clks),
        .cfg_we(cfg_we), .cfg_start(cfg_start), .cfg_sel(cfg_sel),
        .cfg_window(cfg_window), .busy(busy), .done(done),
        .meas_count(meas_count), .ref_remain(ref_remain));

    typedef struct {
        int    sel;
        int    win;
        bit    sat;
        string tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    ended  = 1'b0;

    task automatic check(bit ok, string req, string what, real act, real expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0.2f expected %0.2f", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic issue(int s, int w, bit st);
        @(negedge ref_clk);
        cfg_we     = 1'b1;
        cfg_start  = st;
        cfg_sel    = 2'(s);
        cfg_window = RW'(w);
        @(negedge ref_clk);
        cfg_we    = 1'b0;
        cfg_start = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge ref_clk);
        @(negedge ref_clk);
    endtask

    task automatic start_item(int s, int w, bit sat, string tag);
        item_t it;
        it.sel = s; it.win = w; it.sat = sat; it.tag = tag;
        exp_q.push_back(it);
        issue(s, w, 1'b1);
        // R2: busy due one reference edge after the write
        check(busy == 1'b1, "R2", "busy after start", real'(busy), 1.0);
        check(done == 1'b0, "R2", "done cleared by start", real'(done), 0.0);
    endtask

    task automatic run(int s, int w, bit sat, string tag);
        start_item(s, w, sat, tag);
        wait_empty();
    endtask

    // idle writes without start, then a long wait: nothing may move
    task automatic hold_check();
        int c, r;
        c = int'(meas_count);
        r = int'(ref_remain);
        issue(2, 77, 1'b0);
        check(busy == 1'b0, "R9", "busy after write without start", real'(busy), 0.0);
        repeat (40) @(negedge ref_clk);
        check(done == 1'b1, "R7", "done held", real'(done), 1.0);
        check(int'(meas_count) == c, "R7", "count held", real'(meas_count), real'(c));
        check(int'(ref_remain) == r, "R7", "remain held", real'(ref_remain), real'(r));
    endtask

    // monitor: scores each completion against the queued expectation
    initial begin
        logic done_prev;
        done_prev = 1'b0;
        forever begin
            @(negedge ref_clk);
            if (rst_n && done && !done_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected completion", 1.0, 0.0);
                end else begin
                    item_t it;
                    int    weff;
                    real   expc, expr;
                    it   = exp_q.pop_front();
                    weff = (it.win == 0) ? 1 : it.win;
                    check(busy == 1'b0, "R5", "busy low at done", real'(busy), 0.0);
                    if (!it.sat) begin
                        expc = real'(weff) * REF_PER / per[it.sel];
                        check((real'(meas_count) - expc <= 2.0) && (expc - real'(meas_count) <= 2.0),
                              it.tag, "edge count", real'(meas_count), expc);
                        check(ref_remain == '0, "R5", "window used up", real'(ref_remain), 0.0);
                    end else begin
                        expr = real'(weff) - real'(FULLV) * per[it.sel] / REF_PER - 3.0;
                        check(int'(meas_count) == FULLV, "R6", "saturated count",
                              real'(meas_count), real'(FULLV));
                        check((real'(ref_remain) - expr <= 5.0) && (expr - real'(ref_remain) <= 5.0),
                              "R6", "unused window", real'(ref_remain), expr);
                    end
                end
            end
            done_prev = done;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge ref_clk);
        check(1'b0, "watchdog", "run did not finish", 0.0, 1.0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge ref_clk);
        check(busy == 1'b0, "R1", "busy in reset", real'(busy), 0.0);
        rst_n = 1'b1;
        repeat (3) @(negedge ref_clk);
        check(busy == 1'b0, "R1", "busy after reset", real'(busy), 0.0);
        check(done == 1'b0, "R1", "done after reset", real'(done), 0.0);
        check(meas_count == '0, "R1", "count after reset", real'(meas_count), 0.0);
        check(ref_remain == '0, "R1", "remain after reset", real'(ref_remain), 0.0);

        run(0, 200, 1'b0, "R3");
        run(1, 100, 1'b0, "R4");
        run(2, 511, 1'b0, "R3");
        run(3, 300, 1'b0, "R4");
        run(1, 0,   1'b0, "R3");
        hold_check();

        // R8: a second start with another clock and a short window is ignored
        start_item(0, 200, 1'b0, "R8");
        repeat (5) @(negedge ref_clk);
        issue(3, 50, 1'b1);
        repeat (60) @(negedge ref_clk);
        check(busy == 1'b1, "R8", "still busy past ignored window", real'(busy), 1.0);
        wait_empty();

        run(3, 500, 1'b1, "R6");
        hold_check();
        run(0, 1, 1'b0, "R3");

        finish_run();
    end
endmodule